// File: doc/BRIEF.md
# Branch-Tagged Frontend Stall Ledger

This block keeps a small ring of rows, one for each branch currently in flight in an out-of-order core. Each row collects the instruction-fetch stall cycles that came before its branch was fetched, and counts how long the branch stays in the window after dispatch. When the branch retires, the row sends its counts to the global cycle-accounting counters as a single bulk add. Because only retired rows are ever charged, stall cycles and penalty time that belong to wrong-path branches never reach the global totals.

Three pointers run around the ring. The open pointer marks the row that is collecting stall cycles for the next branch to be fetched. The dispatch pointer marks the next fetched branch still waiting to dispatch. The head marks the oldest dispatched branch, which is the next one to retire. On a mispredicted resolve the block looks up the branch by its reorder-buffer tag, marks the row, and pulls the dispatch and open pointers back to the row just after it. The younger rows are dropped by this move and the row after the branch is cleared. The pipeline must not fetch a branch while `full` is high.

Top module: `branch_stall_ledger`

## Requirements
- R1: After reset `full` and `add_valid` are low and the ring holds no branches.
- R2: Fetching a branch seals the open row as that branch's row. The next row becomes the open row and starts with every count at zero and the mispredict mark clear.
- R3: Each cycle with a fetch stall adds one to exactly one counter in the open row. `stall_itlb` wins over `stall_l2i`, and `stall_l2i` wins over `stall_l1i`.
- R4: On every clock edge, each dispatched and not yet retired branch adds one to its penalty count, except when `rob_full` is high.
- R5: In the cycle `br_retire` is high, `add_valid` is high and the add outputs show the oldest dispatched branch's three stall counts. `add_bp` shows its penalty count only if that branch was resolved as mispredicted; otherwise it is 0.
- R6: A mispredicted resolve whose tag matches a dispatched branch discards every younger branch and every stall cycle collected since that branch. The next branch fetched starts from a cleared row.
- R7: Every row counter saturates at 2^CW-1 and does not wrap.
- R8: `br_retire` with no dispatched branch in the ring has no effect: `add_valid` stays low.
- R9: A resolve with `br_resolve_mp` low, or with a tag that matches no dispatched branch, changes neither the pointers nor any mispredict mark.
- R10: `full` is high while DEPTH-1 branches are fetched and not retired. A fetch while `full` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| br_fetch | input | 1 | A branch was fetched and decoded this cycle |
| br_disp | input | 1 | The oldest undispatched branch dispatches this cycle |
| br_disp_rid | input | RIDW | Reorder-buffer tag of the dispatching branch |
| br_resolve | input | 1 | A branch resolves this cycle |
| br_resolve_mp | input | 1 | The resolving branch was mispredicted |
| br_resolve_rid | input | RIDW | Reorder-buffer tag of the resolving branch |
| br_retire | input | 1 | The oldest branch retires this cycle |
| stall_l1i | input | 1 | Fetch is stalled on a first-level instruction cache miss |
| stall_l2i | input | 1 | Fetch is stalled on a second-level instruction cache miss |
| stall_itlb | input | 1 | Fetch is stalled on an instruction TLB miss |
| rob_full | input | 1 | The reorder buffer is full this cycle |
| full | output | 1 | Ring cannot accept another fetched branch |
| add_valid | output | 1 | Bulk add request to the global counters |
| add_l1i | output | CW | Amount to add to the L1 instruction-miss total |
| add_l2i | output | CW | Amount to add to the L2 instruction-miss total |
| add_itlb | output | CW | Amount to add to the instruction-TLB total |
| add_bp | output | CW | Amount to add to the branch-penalty total |

## Verification
On every cycle the assertions check the pointer invariants: the occupancy bound behind `full`, the ordering of head, dispatch and open pointers, the head stepping once per retire, the realignment after a repair, and that a newly opened row starts clear. The scenarios in the bench are what show that the counts are correct. They cover the stall-cause priority, penalty cycles skipped while the reorder buffer is full, charges that depend on the mispredict mark, wrong-path rows that never reach the outputs, ignored retires and resolves, and saturation after more than 65535 stall cycles.

// File: rtl/branch_stall_ledger.sv
module branch_stall_ledger #(
  parameter int DEPTH = 16,
  parameter int CW    = 16,
  parameter int RIDW  = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            br_fetch,
  input  logic            br_disp,
  input  logic [RIDW-1:0] br_disp_rid,
  input  logic            br_resolve,
  input  logic            br_resolve_mp,
  input  logic [RIDW-1:0] br_resolve_rid,
  input  logic            br_retire,
  input  logic            stall_l1i,
  input  logic            stall_l2i,
  input  logic            stall_itlb,
  input  logic            rob_full,
  output logic            full,
  output logic            add_valid,
  output logic [CW-1:0]   add_l1i,
  output logic [CW-1:0]   add_l2i,
  output logic [CW-1:0]   add_itlb,
  output logic [CW-1:0]   add_bp
);
  localparam int PW = $clog2(DEPTH);
  localparam logic [PW:0] ONE = (PW+1)'(1);
  localparam logic [PW:0] LAST = (PW+1)'(DEPTH-1);
  localparam logic [CW-1:0] CMAX = '1;

  logic [CW-1:0]   c_l1 [DEPTH];
  logic [CW-1:0]   c_l2 [DEPTH];
  logic [CW-1:0]   c_tlb[DEPTH];
  logic [CW-1:0]   c_bp [DEPTH];
  logic [RIDW-1:0] rid  [DEPTH];
  logic [DEPTH-1:0] mpb, inflt;

  logic [PW:0]   hd, dt, fp, n_fet, n_disp, rp;
  logic [PW-1:0] h_i, d_i, f_i, fn_i, hidx;
  logic          hit, mp_go, fetch_ok, disp_ok, ret_ok;
  logic          s_tlb, s_l2, s_l1;

  assign h_i    = hd[PW-1:0];
  assign d_i    = dt[PW-1:0];
  assign f_i    = fp[PW-1:0];
  assign fn_i   = f_i + PW'(1);
  assign n_fet  = fp - hd;
  assign n_disp = dt - hd;
  assign full   = (n_fet == LAST);

  for (genvar g = 0; g < DEPTH; g++) begin : g_inflt
    assign inflt[g] = ({1'b0, PW'(g) - h_i} < n_disp);
  end

  always_comb begin
    hit  = 1'b0;
    hidx = '0;
    for (int i = 0; i < DEPTH; i++)
      if (inflt[i] && rid[i] == br_resolve_rid) begin
        hit  = 1'b1;
        hidx = PW'(i);
      end
  end

  assign rp       = hd + {1'b0, hidx - h_i} + ONE;
  assign mp_go    = br_resolve & br_resolve_mp & hit;
  assign ret_ok   = br_retire & (n_disp != '0);
  assign fetch_ok = br_fetch & ~full & ~mp_go;
  assign disp_ok  = br_disp & (dt != fp) & ~mp_go;

  assign s_tlb = stall_itlb;
  assign s_l2  = stall_l2i & ~stall_itlb;
  assign s_l1  = stall_l1i & ~stall_l2i & ~stall_itlb;

  function automatic logic [CW-1:0] sat(input logic [CW-1:0] v);
    return (v == CMAX) ? v : v + CW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hd  <= '0;
      dt  <= '0;
      fp  <= '0;
      mpb <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        c_l1[i] <= '0; c_l2[i] <= '0; c_tlb[i] <= '0; c_bp[i] <= '0; rid[i] <= '0;
      end
    end else begin
      if (ret_ok) hd <= hd + ONE;
      if (mp_go) begin
        dt <= rp;
        fp <= rp;
      end else begin
        if (fetch_ok) fp <= fp + ONE;
        if (disp_ok)  dt <= dt + ONE;
      end
      for (int i = 0; i < DEPTH; i++) begin
        if ((mp_go && PW'(i) == rp[PW-1:0]) || (fetch_ok && PW'(i) == fn_i)) begin
          c_l1[i] <= '0; c_l2[i] <= '0; c_tlb[i] <= '0; c_bp[i] <= '0;
          rid[i]  <= '0; mpb[i] <= 1'b0;
        end else begin
          if (PW'(i) == f_i) begin
            if (s_l1)  c_l1[i]  <= sat(c_l1[i]);
            if (s_l2)  c_l2[i]  <= sat(c_l2[i]);
            if (s_tlb) c_tlb[i] <= sat(c_tlb[i]);
          end
          if (inflt[i] && !rob_full) c_bp[i] <= sat(c_bp[i]);
          if (disp_ok && PW'(i) == d_i) rid[i] <= br_disp_rid;
          if (mp_go && PW'(i) == hidx) mpb[i] <= 1'b1;
        end
      end
    end
  end

  assign add_valid = ret_ok;
  assign add_l1i   = ret_ok ? c_l1[h_i]  : '0;
  assign add_l2i   = ret_ok ? c_l2[h_i]  : '0;
  assign add_itlb  = ret_ok ? c_tlb[h_i] : '0;
  assign add_bp    = (ret_ok && mpb[h_i]) ? c_bp[h_i] : '0;

  a_r10_occupancy_bound: assert property (@(posedge clk) disable iff (!rst_n)
    n_fet <= LAST);
  a_r6_pointer_order: assert property (@(posedge clk) disable iff (!rst_n)
    n_disp <= n_fet);
  a_r6_repair_aligns: assert property (@(posedge clk) disable iff (!rst_n)
    mp_go |=> (fp == dt));
  a_r5_head_steps: assert property (@(posedge clk) disable iff (!rst_n)
    ret_ok |=> (hd == $past(hd) + ONE));
  a_r2_fresh_row: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_ok |=> (c_l1[f_i] == '0 && c_l2[f_i] == '0 && c_tlb[f_i] == '0 && !mpb[f_i]));
endmodule

// File: tb/branch_stall_ledger_test.sv
module branch_stall_ledger_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic br_fetch = 0, br_disp = 0, br_resolve = 0, br_resolve_mp = 0, br_retire = 0;
  logic [5:0] br_disp_rid = '0, br_resolve_rid = '0;
  logic stall_l1i = 0, stall_l2i = 0, stall_itlb = 0, rob_full = 0;
  logic full, add_valid;
  logic [15:0] add_l1i, add_l2i, add_itlb, add_bp;
  int vecs = 0, errs = 0, ticks = 0;

  branch_stall_ledger uut (.*);

  always #10 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    vecs++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1; ticks++;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; repeat (2) tick(); rst_n = 1'b1; tick();
  endtask

  task automatic fetch1();
    br_fetch = 1; tick(); br_fetch = 0;
  endtask

  task automatic disp1(input logic [5:0] r, output int td);
    br_disp = 1; br_disp_rid = r; tick(); br_disp = 0; td = ticks;
  endtask

  task automatic stall(input logic a, input logic b, input logic c, input int n);
    stall_l1i = a; stall_l2i = b; stall_itlb = c;
    repeat (n) tick();
    stall_l1i = 0; stall_l2i = 0; stall_itlb = 0;
  endtask

  task automatic resolve(input logic [5:0] r, input logic mp);
    br_resolve = 1; br_resolve_mp = mp; br_resolve_rid = r; tick();
    br_resolve = 0; br_resolve_mp = 0;
  endtask

  task automatic retire_chk(input string req, input int l1, input int l2, input int tl, input int bp);
    br_retire = 1; #1;
    chk({req, " add_valid"}, add_valid, 1);
    chk({req, " add_l1i"}, add_l1i, l1);
    chk({req, " add_l2i"}, add_l2i, l2);
    chk({req, " add_itlb"}, add_itlb, tl);
    chk({req, " add_bp"}, add_bp, bp);
    tick(); br_retire = 0;
  endtask

  task automatic retire_none(input string req);
    br_retire = 1; #1;
    chk({req, " add_valid on empty retire"}, add_valid, 0);
    tick(); br_retire = 0;
  endtask

  task automatic t_reset();
    do_reset(); #1;
    chk("R1 full", full, 0);
    chk("R1 add_valid", add_valid, 0);
    retire_none("R8");
  endtask

  task automatic t_priority();
    int td;
    stall(1, 1, 1, 3);
    stall(1, 1, 0, 4);
    stall(1, 0, 0, 5);
    fetch1(); disp1(6'd3, td);
    repeat (7) tick();
    retire_chk("R3/R5", 5, 4, 3, 0);
    retire_none("R8");
  endtask

  task automatic t_penalty();
    int td;
    fetch1(); disp1(6'd7, td);
    repeat (4) tick();
    rob_full = 1; repeat (3) tick(); rob_full = 0;
    repeat (2) tick();
    resolve(6'd7, 1);
    tick();
    retire_chk("R2/R4", 0, 0, 0, ticks - td - 3);
  endtask

  task automatic t_ignored_resolve();
    int ta, tb;
    fetch1(); disp1(6'd10, ta);
    resolve(6'd10, 0);
    resolve(6'd20, 1);
    stall(0, 1, 0, 2);
    fetch1(); disp1(6'd11, tb);
    retire_chk("R9 first", 0, 0, 0, 0);
    retire_chk("R9 second", 0, 2, 0, 0);
  endtask

  task automatic t_repair();
    int ta, tb, tdd;
    stall(1, 0, 0, 2);
    fetch1(); disp1(6'd1, ta);
    stall(1, 0, 0, 3);
    fetch1(); disp1(6'd2, tb);
    stall(0, 1, 0, 4);
    fetch1();
    resolve(6'd1, 1);
    stall(0, 0, 1, 6);
    fetch1(); disp1(6'd4, tdd);
    retire_chk("R6 mispredicted", 2, 0, 0, ticks - ta);
    retire_chk("R6 correct path", 0, 0, 6, 0);
    retire_none("R6");
  endtask

  task automatic t_full();
    int td;
    do_reset();
    repeat (14) fetch1();
    #1 chk("R10 below limit", full, 0);
    fetch1();
    #1 chk("R10 at limit", full, 1);
    fetch1();
    disp1(6'd0, td);
    retire_chk("R10 drain", 0, 0, 0, 0);
    #1 chk("R10 ignored fetch", full, 0);
  endtask

  task automatic t_sat();
    int td;
    do_reset();
    stall(1, 0, 0, 65600);
    fetch1(); disp1(6'd9, td);
    retire_chk("R7", 65535, 0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    t_reset();
    t_priority();
    t_penalty();
    t_ignored_resolve();
    t_repair();
    t_full();
    t_sat();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule